// File: doc/BRIEF.md
# Device Power State Controller

This block sequences the power states of a bus-attached network peripheral. It holds one of four device states: cold reset, powered but uninitialized, active, and the low-power hot state that stays visible on the bus. It reacts to power-good, a fundamental bus reset line, configuration writes to a two-bit power-state field, and writes to the memory and I/O decode bits of the command register. It drives the PHY reset, the datapath and clock enables, the decode and bus-master enables, and the wake-up controls.

Each entry into the uninitialized state starts a non-volatile configuration load. The request is `nvm_load_o` and the completion strobe is `nvm_done_i`. While the load runs, every wake-up source is masked, the PHY is held in reset, and configuration writes are held off. When the load completes, the APM wake enable and the manageability enable are taken from the loaded bits.

A cold start from reset leaves nothing behind. A return from the hot low-power state keeps the wake filter setting that software programmed earlier, but it reloads the APM wake enable from the loaded configuration.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `rst_ni` is low, `state_o` is 00. The state encoding is 00 cold reset, 01 uninitialized, 10 active and 11 hot low-power. In that reset state `phy_rst_o` is 1, and every enable, every decode output, `apm_wake_o`, `wake_flt_o`, `nvm_load_o` and `cfg_ready_o` are 0.
- R2: `bus_rst_i` high forces the reset state and clears all held settings on the next clock edge, from any state. It overrides a configuration write made in the same cycle.
- R3: In the reset state, with `pwr_good_i` high, the block moves to uninitialized (01) and raises `nvm_load_o`. While the load is pending, `phy_rst_o` is 1, `cfg_ready_o` is 0, and `apm_wake_o` and `wake_flt_o` are 0.
- R4: `nvm_done_i` during a pending load ends the load. It copies `nvm_apm_i` into the APM wake enable and `nvm_mng_i` into the manageability enable. Outside a load, `nvm_done_i` has no effect.
- R5: In the uninitialized state after the load, a command write with the memory bit or the I/O bit set moves the block to active (10). A command write with both bits at 0 leaves the state unchanged.
- R6: In the active state, `clk_en_o`, `dma_en_o`, `mac_en_o`, `phy_en_o` and `master_en_o` are 1 and `phy_rst_o` is 0. `mem_dec_o` and `io_dec_o` show the last written command bits. `mng_en_o` equals the loaded manageability bit.
- R7: Writes to the APM wake control and to the wake filter take effect only in the active state. In every other state they are ignored.
- R8: A power-state write of 11 from uninitialized or active moves the block to the hot state (11). On that move both decode bits are cleared, and the datapath, clock and master enables drop. The wake filter and the APM wake enable keep their values. If a command write arrives in the same cycle, the power-state write wins.
- R9: A power-state write of 00 in the hot state returns the block to uninitialized and starts a new load. The APM wake enable is cleared and then reloaded from `nvm_apm_i`. The wake filter value is kept and shows again on `wake_flt_o` once the load ends.
- R10: Power-state writes of 01 or 10 never change the state. A write of 00 in the uninitialized or active state changes nothing, and neither does a write of 11 in the hot state.
- R11: Power-state and command writes are ignored in the reset state and while a load is pending. Command writes are also ignored in the hot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Fundamental bus reset, active high |
| pwr_good_i | input | 1 | Internal power good |
| ps_we_i | input | 1 | Power-state field write strobe |
| ps_i | input | 2 | Power-state field write value |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_mem_i | input | 1 | Memory decode bit of the command write |
| cmd_io_i | input | 1 | I/O decode bit of the command write |
| nvm_done_i | input | 1 | Configuration load complete |
| nvm_apm_i | input | 1 | Loaded APM wake enable bit |
| nvm_mng_i | input | 1 | Loaded manageability enable bit |
| wake_ctl_we_i | input | 1 | APM wake control write strobe |
| wake_ctl_apm_i | input | 1 | APM wake control write value |
| wake_flt_we_i | input | 1 | Wake filter write strobe |
| wake_flt_i | input | FLT_W | Wake filter write value |
| state_o | output | 2 | Device state |
| phy_rst_o | output | 1 | PHY reset |
| dma_en_o | output | 1 | DMA enable |
| mac_en_o | output | 1 | MAC enable |
| phy_en_o | output | 1 | PHY enable |
| clk_en_o | output | 1 | Internal clock enable |
| mem_dec_o | output | 1 | Memory decode enable |
| io_dec_o | output | 1 | I/O decode enable |
| master_en_o | output | 1 | Bus master cycle enable |
| mng_en_o | output | 1 | Manageability enable |
| apm_wake_o | output | 1 | APM wake enabled |
| wake_flt_o | output | FLT_W | Effective wake filter enables |
| nvm_load_o | output | 1 | Configuration load request |
| cfg_ready_o | output | 1 | Configuration access allowed |

## Verification
The bench checks how a return from the hot state differs from a cold start. A design that cleared the wake filter on that return would show a zero filter after the reload. A design that skipped the reload would keep a stale APM enable. It also checks a bus reset that arrives together with a configuration write. If the write won, the block would be left outside the reset state. Reserved power-state values and writes made during a load must leave the state and the decode bits unchanged; a wrong design would move to a new state or enable decoding early. Finally, a power-state write to the hot state that meets a command write in the same cycle must not leave a decode bit set while the block is in the hot state.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;
  typedef enum logic [1:0] {
    ST_RST = 2'b00,
    ST_D0U = 2'b01,
    ST_D0A = 2'b10,
    ST_D3  = 2'b11
  } pstate_e;

  localparam logic [1:0] PS_D0 = 2'b00;
  localparam logic [1:0] PS_D3 = 2'b11;
endpackage

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rst_i,
  input  logic       pwr_good_i,
  input  logic       ps_we_i,
  input  logic [1:0] ps_i,
  input  logic       cmd_we_i,
  input  logic       cmd_mem_i,
  input  logic       cmd_io_i,
  input  logic       nvm_done_i,
  output pstate_e    state_o,
  output logic       loading_o,
  output logic       cfg_ok_o,
  output logic       enter_d0u_o,
  output logic       enter_d3_o,
  output logic       load_done_o
);
  pstate_e state_q, state_d;
  logic    load_q;

  assign cfg_ok_o = (state_q != ST_RST) && !load_q;

  always_comb begin
    state_d = state_q;
    if (bus_rst_i) begin
      state_d = ST_RST;
    end else begin
      unique case (state_q)
        ST_RST: if (pwr_good_i) state_d = ST_D0U;
        ST_D0U: begin
          if (cfg_ok_o && ps_we_i && ps_i == PS_D3) state_d = ST_D3;
          else if (cfg_ok_o && cmd_we_i && (cmd_mem_i || cmd_io_i)) state_d = ST_D0A;
        end
        ST_D0A: if (ps_we_i && ps_i == PS_D3) state_d = ST_D3;
        ST_D3:  if (ps_we_i && ps_i == PS_D0) state_d = ST_D0U;
        default: state_d = ST_RST;
      endcase
    end
  end

  assign enter_d0u_o = (state_d == ST_D0U) && (state_q != ST_D0U);
  assign enter_d3_o  = (state_d == ST_D3) && (state_q != ST_D3);
  assign load_done_o = load_q && nvm_done_i && !bus_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (bus_rst_i)        load_q <= 1'b0;
      else if (enter_d0u_o) load_q <= 1'b1;
      else if (nvm_done_i)  load_q <= 1'b0;
    end
  end

  assign state_o   = state_q;
  assign loading_o = load_q;

  AST_BUS_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> state_q == ST_RST); // R2

  AST_PS_RESERVED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_we_i && (ps_i == 2'b01 || ps_i == 2'b10) && !bus_rst_i && !cmd_we_i && !(state_q == ST_RST && pwr_good_i))
      |=> state_q == $past(state_q)); // R10

  AST_LOAD_HOLDS_D0U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && state_q == ST_D0U && !bus_rst_i) |=> state_q == ST_D0U); // R11
endmodule

// File: rtl/pwr_cmd_regs.sv
`timescale 1ns/1ps
module pwr_cmd_regs
  import pwr_state_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    enter_d3_i,
  input  logic    cfg_ok_i,
  input  pstate_e state_i,
  input  logic    cmd_we_i,
  input  logic    cmd_mem_i,
  input  logic    cmd_io_i,
  output logic    mem_o,
  output logic    io_o
);
  logic mem_q, io_q, wr;

  // command writes land only in D0 states with config access open
  assign wr = cmd_we_i && cfg_ok_i && (state_i == ST_D0U || state_i == ST_D0A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= 1'b0;
      io_q  <= 1'b0;
    end else if (clr_i || enter_d3_i) begin
      mem_q <= 1'b0;
      io_q  <= 1'b0;
    end else if (wr) begin
      mem_q <= cmd_mem_i;
      io_q  <= cmd_io_i;
    end
  end

  assign mem_o = mem_q;
  assign io_o  = io_q;

  AST_D3_NO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_D3 |-> !mem_q && !io_q); // R8
endmodule

// File: rtl/pwr_wake_regs.sv
`timescale 1ns/1ps
module pwr_wake_regs
  import pwr_state_pkg::*;
#(
  parameter int FLT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             enter_d0u_i,
  input  logic             load_done_i,
  input  logic             nvm_apm_i,
  input  logic             nvm_mng_i,
  input  pstate_e          state_i,
  input  logic             ctl_we_i,
  input  logic             ctl_apm_i,
  input  logic             flt_we_i,
  input  logic [FLT_W-1:0] flt_i,
  output logic             apm_o,
  output logic             mng_o,
  output logic [FLT_W-1:0] flt_o
);
  logic             apm_q, mng_q;
  logic [FLT_W-1:0] flt_q;
  logic             sw_ok;

  assign sw_ok = (state_i == ST_D0A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      apm_q <= 1'b0;
      mng_q <= 1'b0;
      flt_q <= '0;
    end else if (clr_i) begin
      apm_q <= 1'b0;
      mng_q <= 1'b0;
      flt_q <= '0;
    end else if (enter_d0u_i) begin
      // filter survives; NVM-sourced bits wait for reload
      apm_q <= 1'b0;
      mng_q <= 1'b0;
    end else if (load_done_i) begin
      apm_q <= nvm_apm_i;
      mng_q <= nvm_mng_i;
    end else if (sw_ok) begin
      if (ctl_we_i) apm_q <= ctl_apm_i;
      if (flt_we_i) flt_q <= flt_i;
    end
  end

  assign apm_o = apm_q;
  assign mng_o = mng_q;
  assign flt_o = flt_q;

  AST_D3_FLT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_D3 && !clr_i) |=> flt_q == $past(flt_q)); // R8

  AST_D0U_ENTRY_CLR_APM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_d0u_i |=> !apm_q && !mng_q); // R9
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int FLT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             pwr_good_i,
  input  logic             ps_we_i,
  input  logic [1:0]       ps_i,
  input  logic             cmd_we_i,
  input  logic             cmd_mem_i,
  input  logic             cmd_io_i,
  input  logic             nvm_done_i,
  input  logic             nvm_apm_i,
  input  logic             nvm_mng_i,
  input  logic             wake_ctl_we_i,
  input  logic             wake_ctl_apm_i,
  input  logic             wake_flt_we_i,
  input  logic [FLT_W-1:0] wake_flt_i,
  output logic [1:0]       state_o,
  output logic             phy_rst_o,
  output logic             dma_en_o,
  output logic             mac_en_o,
  output logic             phy_en_o,
  output logic             clk_en_o,
  output logic             mem_dec_o,
  output logic             io_dec_o,
  output logic             master_en_o,
  output logic             mng_en_o,
  output logic             apm_wake_o,
  output logic [FLT_W-1:0] wake_flt_o,
  output logic             nvm_load_o,
  output logic             cfg_ready_o
);
  pstate_e          state;
  logic             loading, cfg_ok, enter_d0u, enter_d3, load_done;
  logic             apm_q, mng_q;
  logic [FLT_W-1:0] flt_q;
  logic             active;

  pwr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_rst_i   (bus_rst_i),
    .pwr_good_i  (pwr_good_i),
    .ps_we_i     (ps_we_i),
    .ps_i        (ps_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_mem_i   (cmd_mem_i),
    .cmd_io_i    (cmd_io_i),
    .nvm_done_i  (nvm_done_i),
    .state_o     (state),
    .loading_o   (loading),
    .cfg_ok_o    (cfg_ok),
    .enter_d0u_o (enter_d0u),
    .enter_d3_o  (enter_d3),
    .load_done_o (load_done)
  );

  pwr_cmd_regs u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (bus_rst_i),
    .enter_d3_i (enter_d3),
    .cfg_ok_i   (cfg_ok),
    .state_i    (state),
    .cmd_we_i   (cmd_we_i),
    .cmd_mem_i  (cmd_mem_i),
    .cmd_io_i   (cmd_io_i),
    .mem_o      (mem_dec_o),
    .io_o       (io_dec_o)
  );

  pwr_wake_regs #(.FLT_W(FLT_W)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (bus_rst_i),
    .enter_d0u_i (enter_d0u),
    .load_done_i (load_done),
    .nvm_apm_i   (nvm_apm_i),
    .nvm_mng_i   (nvm_mng_i),
    .state_i     (state),
    .ctl_we_i    (wake_ctl_we_i),
    .ctl_apm_i   (wake_ctl_apm_i),
    .flt_we_i    (wake_flt_we_i),
    .flt_i       (wake_flt_i),
    .apm_o       (apm_q),
    .mng_o       (mng_q),
    .flt_o       (flt_q)
  );

  assign active      = (state == ST_D0A);
  assign state_o     = state;
  assign phy_rst_o   = (state == ST_RST) || loading;
  assign dma_en_o    = active;
  assign mac_en_o    = active;
  assign phy_en_o    = active;
  assign clk_en_o    = active;
  assign master_en_o = active;
  assign mng_en_o    = active && mng_q;
  // all wake sources masked during configuration load
  assign apm_wake_o  = apm_q && !loading;
  assign wake_flt_o  = loading ? '0 : flt_q;
  assign nvm_load_o  = loading;
  assign cfg_ready_o = cfg_ok;

  AST_D0A_ONLY_FROM_D0U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_D0A && $past(state_o) != ST_D0A) |-> $past(state_o) == ST_D0U); // R5

  AST_LOAD_MASKS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_load_o |-> phy_rst_o && !apm_wake_o && wake_flt_o == '0 && !cfg_ready_o); // R3
endmodule

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_state_ctrl_bench;
  localparam int FLT_W = 8;
  localparam int OW = 14 + FLT_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rst_i = 0, pwr_good_i = 0, ps_we_i = 0, cmd_we_i = 0, cmd_mem_i = 0, cmd_io_i = 0;
  logic [1:0] ps_i = 0;
  logic nvm_done_i = 0, nvm_apm_i = 0, nvm_mng_i = 0;
  logic wake_ctl_we_i = 0, wake_ctl_apm_i = 0, wake_flt_we_i = 0;
  logic [FLT_W-1:0] wake_flt_i = 0;
  logic [1:0] state_o;
  logic phy_rst_o, dma_en_o, mac_en_o, phy_en_o, clk_en_o, mem_dec_o, io_dec_o;
  logic master_en_o, mng_en_o, apm_wake_o, nvm_load_o, cfg_ready_o;
  logic [FLT_W-1:0] wake_flt_o;

  pwr_state_ctrl #(.FLT_W(FLT_W)) u_pwr_state_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [1:0] m_st;
  logic m_load, m_mem, m_io, m_apm, m_mng;
  logic [FLT_W-1:0] m_flt;

  task automatic model_reset();
    m_st = 2'b00; m_load = 0; m_mem = 0; m_io = 0; m_apm = 0; m_mng = 0; m_flt = '0;
  endtask

  task automatic model_step();
    logic [1:0] nst;
    logic ok;
    if (bus_rst_i) begin
      model_reset();
      return;
    end
    ok = (m_st != 2'b00) && !m_load;
    nst = m_st;
    case (m_st)
      2'b00: if (pwr_good_i) nst = 2'b01;
      2'b01: if (ok && ps_we_i && ps_i == 2'b11) nst = 2'b11;
             else if (ok && cmd_we_i && (cmd_mem_i || cmd_io_i)) nst = 2'b10;
      2'b10: if (ps_we_i && ps_i == 2'b11) nst = 2'b11;
      default: if (ps_we_i && ps_i == 2'b00) nst = 2'b01;
    endcase
    if (nst == 2'b11 && m_st != 2'b11) begin m_mem = 0; m_io = 0; end
    else if (cmd_we_i && ok && (m_st == 2'b01 || m_st == 2'b10)) begin
      m_mem = cmd_mem_i; m_io = cmd_io_i;
    end
    if (nst == 2'b01 && m_st != 2'b01) begin m_apm = 0; m_mng = 0; end
    else if (m_load && nvm_done_i) begin m_apm = nvm_apm_i; m_mng = nvm_mng_i; end
    else if (m_st == 2'b10) begin
      if (wake_ctl_we_i) m_apm = wake_ctl_apm_i;
      if (wake_flt_we_i) m_flt = wake_flt_i;
    end
    if (nst == 2'b01 && m_st != 2'b01) m_load = 1;
    else if (nvm_done_i) m_load = 0;
    m_st = nst;
  endtask

  function automatic logic [OW-1:0] expect_out();
    logic a;
    a = (m_st == 2'b10);
    return {m_st, (m_st == 2'b00) || m_load, a, a, a, a, m_mem, m_io, a, a && m_mng,
            m_apm && !m_load, m_load ? {FLT_W{1'b0}} : m_flt, m_load,
            (m_st != 2'b00) && !m_load};
  endfunction

  function automatic logic [OW-1:0] actual_out();
    return {state_o, phy_rst_o, dma_en_o, mac_en_o, phy_en_o, clk_en_o, mem_dec_o, io_dec_o,
            master_en_o, mng_en_o, apm_wake_o, wake_flt_o, nvm_load_o, cfg_ready_o};
  endfunction

  task automatic chk(string tag);
    logic [OW-1:0] e, a;
    e = expect_out();
    a = actual_out();
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic chk_state(string tag, logic [1:0] exp_st);
    n_chk++;
    if (state_o !== exp_st) begin
      n_fail++;
      $display("FAIL %s: state actual=%b expected=%b", tag, state_o, exp_st);
    end
  endtask

  task automatic idle();
    bus_rst_i = 0; ps_we_i = 0; cmd_we_i = 0; nvm_done_i = 0;
    wake_ctl_we_i = 0; wake_flt_we_i = 0;
  endtask

  // inputs set after a negedge; model follows the edge; compare at next negedge
  task automatic cycle();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 reset state");
    rst_ni = 1;
    cycle(); chk("R1 held reset without power good");

    pwr_good_i = 1; cycle(); idle();
    chk("R3 enter uninitialized, load pending"); chk_state("R3", 2'b01);
    cmd_we_i = 1; cmd_mem_i = 1; ps_we_i = 1; ps_i = 2'b11; cycle(); idle();
    chk("R11 writes ignored during load"); chk_state("R11", 2'b01);
    nvm_apm_i = 1; nvm_mng_i = 1; nvm_done_i = 1; cycle(); idle();
    chk("R4 load done loads apm and mng");
    nvm_apm_i = 0; nvm_done_i = 1; cycle(); idle();
    chk("R4 done outside load ignored");
    ps_we_i = 1; ps_i = 2'b01; cycle(); idle(); chk("R10 D1 write ignored");
    ps_we_i = 1; ps_i = 2'b00; cycle(); idle(); chk("R10 D0 write in D0 ignored");
    wake_flt_we_i = 1; wake_flt_i = 8'h3c; cycle(); idle(); chk("R7 filter write ignored outside active");
    cmd_we_i = 1; cmd_mem_i = 0; cmd_io_i = 0; cycle(); idle();
    chk("R5 zero command write stays"); chk_state("R5", 2'b01);
    cmd_we_i = 1; cmd_io_i = 1; cycle(); idle();
    chk("R6 active via io bit"); chk_state("R5", 2'b10);
    wake_flt_we_i = 1; wake_flt_i = 8'ha5; wake_ctl_we_i = 1; wake_ctl_apm_i = 0; cycle(); idle();
    chk("R7 wake writes in active");
    wake_ctl_we_i = 1; wake_ctl_apm_i = 1; cycle(); idle(); chk("R7 apm set again");
    ps_we_i = 1; ps_i = 2'b10; cycle(); idle(); chk("R10 D2 write ignored");
    ps_we_i = 1; ps_i = 2'b11; cycle(); idle();
    chk("R8 enter hot, decodes cleared, wake kept"); chk_state("R8", 2'b11);
    wake_flt_we_i = 1; wake_flt_i = 8'h00; wake_ctl_we_i = 1; wake_ctl_apm_i = 0;
    cmd_we_i = 1; cmd_mem_i = 1; cycle(); idle();
    chk("R7 R11 writes ignored in hot state");
    ps_we_i = 1; ps_i = 2'b11; cycle(); idle(); chk("R10 D3 write in D3 no change");
    ps_we_i = 1; ps_i = 2'b00; cycle(); idle();
    chk("R9 return to uninitialized, wake masked");
    nvm_apm_i = 0; nvm_done_i = 1; cycle(); idle();
    chk("R9 filter kept, apm reloaded");
    cmd_we_i = 1; cmd_mem_i = 1; cmd_io_i = 0; ps_we_i = 1; ps_i = 2'b11; cycle(); idle();
    chk("R8 power-state write beats command write"); chk_state("R8", 2'b11);
    bus_rst_i = 1; ps_we_i = 1; ps_i = 2'b00; cycle(); idle();
    chk("R2 bus reset beats config write"); chk_state("R2", 2'b00);

    for (int i = 0; i < 4000; i++) begin
      bus_rst_i      = ($urandom % 64) == 0;
      pwr_good_i     = ($urandom % 8) != 0;
      ps_we_i        = ($urandom % 6) == 0;
      ps_i           = 2'($urandom);
      cmd_we_i       = ($urandom % 5) == 0;
      cmd_mem_i      = 1'($urandom);
      cmd_io_i       = 1'($urandom);
      nvm_done_i     = ($urandom % 4) == 0;
      nvm_apm_i      = 1'($urandom);
      nvm_mng_i      = 1'($urandom);
      wake_ctl_we_i  = ($urandom % 6) == 0;
      wake_ctl_apm_i = 1'($urandom);
      wake_flt_we_i  = ($urandom % 6) == 0;
      wake_flt_i     = FLT_W'($urandom);
      cycle();
      chk("R2-model random");
    end
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule